// File: doc/BRIEF.md
# Triggered Arbitrary Waveform Playback Engine

This block stores a waveform of up to 1024 samples, each 12 bits wide, in a two-port memory and replays it to a parallel digital-to-analog converter. A host fills and inspects the waveform through an addressed register bus with 16-bit data, running on its own bus clock. Playback runs on a separate converter clock. Each playback cycle presents one sample, and a strobe marks each cycle that carries a new sample.

Nothing plays until the host writes a start command. The control write also picks the run type. A one-shot run stops after the last sample. A looping run goes back to entry 0 after the last sample without a gap, and continues until the host sends a stop command. A length register sets the last entry that is played, so a waveform can be shorter than the buffer. The start and stop commands cross into the converter domain as toggles, so a single command is never lost. The mode and length values are synchronised and latched when the run begins. A busy flag returns from the converter domain so the host can see when a run has finished.

Top module: `awg_playback`

## Requirements
- R1: After reset, `dac_data` is 0x800, `dac_valid` is 0 and the busy flag (bit 0 of the control register) reads 0.
- R2: A bus address with bit 10 clear selects buffer entry `bus_addr[9:0]`. A write stores `bus_wdata[11:0]`. A read returns the stored value in bits 11:0 with bits 15:12 zero, two bus clocks after the request. Writes and reads are allowed while playback runs.
- R3: The length register at address 0x401 stores a 10-bit last-entry index and reads it back zero-extended.
- R4: `dac_valid` stays low until the host writes bit 0 (start) to the control register at 0x400.
- R5: In one-shot mode (bit 2 of the start write clear), entries 0 through the last-entry index are presented in order, one per strobe cycle. The strobe then goes low and stays low.
- R6: In looping mode (bit 2 of the start write set), entry 0 follows the last entry, and the strobe stays high on every converter cycle until a stop is received.
- R7: Writing bit 1 (stop) to the control register ends playback. A stop takes precedence over a start in the same write. After the stop, the strobe goes low and busy clears.
- R8: A start written while busy reads 0 makes busy read 1 from the next bus cycle. Busy stays 1 until the run ends. Bit 2 of a control read returns the last written mode bit.
- R9: While the strobe is low, `dac_data` holds the last sample played.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Host bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 11 | Bit 10 selects registers; bits 9:0 give the buffer index or register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid two bus clocks after the request |
| cnv_clk | input | 1 | Converter clock |
| cnv_rst | input | 1 | Synchronous active-high reset, converter domain |
| dac_data | output | 12 | Sample presented to the converter |
| dac_valid | output | 1 | High when `dac_data` carries a new sample this cycle |

## Verification
A wrong sequencer address shows up on the first strobe after the fault as a sample out of order against the host-loaded buffer. In looping mode it shows at the wrap, where entry 0 must follow the last entry directly. A lost or repeated start toggle shows within a few converter cycles, as samples that never appear or that appear without a command. A stuck run flag shows as busy never clearing on the bus, or as strobes after a stop. A corrupted output register shows as `dac_data` moving while the strobe is low.

// File: rtl/awg_pkg.sv
package awg_pkg;
  localparam int BUS_W     = 16;
  localparam int OFF_CTRL  = 0;
  localparam int OFF_LEN   = 1;
  localparam int CB_START  = 0;
  localparam int CB_STOP   = 1;
  localparam int CB_LOOP   = 2;
  localparam int SYNC_LEN  = 2;
endpackage

// File: rtl/awg_dpram.sv
module awg_dpram #(
  parameter int W  = 12,
  parameter int AW = 10
) (
  input  logic          clk_a,
  input  logic          we_a,
  input  logic [AW-1:0] addr_a,
  input  logic [W-1:0]  wdata_a,
  output logic [W-1:0]  q_a,
  input  logic          clk_b,
  input  logic          re_b,
  input  logic [AW-1:0] addr_b,
  output logic [W-1:0]  q_b
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_a) begin
    if (we_a) mem[addr_a] <= wdata_a;
    q_a <= mem[addr_a];
  end

  always_ff @(posedge clk_b) begin
    if (re_b) q_b <= mem[addr_b];
  end
endmodule

// File: rtl/awg_host_regs.sv
module awg_host_regs
  import awg_pkg::*;
#(
  parameter int SW = 12,
  parameter int AW = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             wr,
  input  logic [AW:0]      addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  output logic             buf_we,
  output logic [SW-1:0]    buf_wdata,
  input  logic [SW-1:0]    buf_q,
  output logic             start_tog,
  output logic             stop_tog,
  output logic             loop_lvl,
  output logic [AW-1:0]    len_lvl,
  input  logic             ack_tog,
  input  logic             run_lvl
);
  logic            is_reg, wr_reg, busy, pending;
  logic [SYNC_LEN-1:0] ack_s, run_s;
  logic            rd_pend, rd_is_reg;
  logic [BUS_W-1:0] rd_val;
  logic            unused_hi;

  assign is_reg    = addr[AW];
  assign wr_reg    = sel && wr && is_reg;
  assign buf_we    = sel && wr && !is_reg;
  assign buf_wdata = wdata[SW-1:0];
  assign unused_hi = ^wdata[BUS_W-1:SW];
  assign pending   = start_tog ^ ack_s[SYNC_LEN-1];
  assign busy      = pending || run_s[SYNC_LEN-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      start_tog <= 1'b0;
      stop_tog  <= 1'b0;
      loop_lvl  <= 1'b0;
      len_lvl   <= '0;
      ack_s     <= '0;
      run_s     <= '0;
      rd_pend   <= 1'b0;
      rd_is_reg <= 1'b0;
      rd_val    <= '0;
      rdata     <= '0;
    end else begin
      ack_s <= {ack_s[SYNC_LEN-2:0], ack_tog};
      run_s <= {run_s[SYNC_LEN-2:0], run_lvl};
      if (wr_reg && addr[AW-1:0] == AW'(OFF_CTRL)) begin
        loop_lvl <= wdata[CB_LOOP];
        if (wdata[CB_STOP])
          stop_tog <= ~stop_tog;
        else if (wdata[CB_START] && !pending)
          start_tog <= ~start_tog;
      end
      if (wr_reg && addr[AW-1:0] == AW'(OFF_LEN))
        len_lvl <= wdata[AW-1:0];
      rd_pend   <= sel && !wr;
      rd_is_reg <= is_reg;
      rd_val    <= '0;
      if (addr[AW-1:0] == AW'(OFF_CTRL)) begin
        rd_val[0]       <= busy;
        rd_val[CB_LOOP] <= loop_lvl;
      end else if (addr[AW-1:0] == AW'(OFF_LEN)) begin
        rd_val[AW-1:0]  <= len_lvl;
      end
      if (rd_pend)
        rdata <= rd_is_reg ? rd_val : BUS_W'(buf_q);
    end
  end

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    (wr_reg && addr[AW-1:0] == AW'(OFF_CTRL) && wdata[CB_START] && !wdata[CB_STOP] && !busy)
      |=> busy) else $error("busy not set by start"); // R8
endmodule

// File: rtl/awg_sequencer.sv
module awg_sequencer
  import awg_pkg::*;
#(
  parameter int SW = 12,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_tog,
  input  logic          stop_tog,
  input  logic          loop_lvl,
  input  logic [AW-1:0] len_lvl,
  input  logic [SW-1:0] q_b,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          ack_tog,
  output logic          running,
  output logic [SW-1:0] dac_data,
  output logic          dac_valid
);
  localparam logic [SW-1:0] MID = SW'(1) << (SW - 1);

  logic [SYNC_LEN:0]   start_s, stop_s;
  logic [SYNC_LEN-1:0] loop_s;
  logic [AW-1:0]       len_s [SYNC_LEN];
  logic                start_edge, stop_edge, loop_q, fetch_v;
  logic [AW-1:0]       addr, last_q;

  assign start_edge = start_s[SYNC_LEN] ^ start_s[SYNC_LEN-1];
  assign stop_edge  = stop_s[SYNC_LEN] ^ stop_s[SYNC_LEN-1];
  assign rd_en      = running;
  assign rd_addr    = addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_s <= '0;
      stop_s  <= '0;
      loop_s  <= '0;
      for (int i = 0; i < SYNC_LEN; i++) len_s[i] <= '0;
    end else begin
      start_s  <= {start_s[SYNC_LEN-1:0], start_tog};
      stop_s   <= {stop_s[SYNC_LEN-1:0], stop_tog};
      loop_s   <= {loop_s[SYNC_LEN-2:0], loop_lvl};
      len_s[0] <= len_lvl;
      for (int i = 1; i < SYNC_LEN; i++) len_s[i] <= len_s[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      addr      <= '0;
      last_q    <= '0;
      loop_q    <= 1'b0;
      ack_tog   <= 1'b0;
      fetch_v   <= 1'b0;
      dac_data  <= MID;
      dac_valid <= 1'b0;
    end else begin
      fetch_v   <= running;
      dac_valid <= fetch_v;
      if (fetch_v) dac_data <= q_b;
      if (start_edge) begin
        running <= 1'b1;
        addr    <= '0;
        last_q  <= len_s[SYNC_LEN-1];
        loop_q  <= loop_s[SYNC_LEN-1];
        ack_tog <= ~ack_tog;
      end else if (stop_edge) begin
        running <= 1'b0;
      end else if (running) begin
        if (addr == last_q) begin
          addr <= '0;
          if (!loop_q) running <= 1'b0;
        end else begin
          addr <= addr + 1'b1;
        end
      end
    end
  end

  AST_IDLE_NO_RUN: assert property (@(posedge clk) disable iff (rst)
    (!running && !start_edge) |=> !running) else $error("run without start"); // R4
  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    running |-> addr <= last_q) else $error("address past end"); // R5
  AST_ONESHOT_END: assert property (@(posedge clk) disable iff (rst)
    (running && !loop_q && addr == last_q && !start_edge && !stop_edge) |=> !running)
    else $error("one-shot did not end"); // R5
  AST_LOOP_NO_GAP: assert property (@(posedge clk) disable iff (rst)
    (running && loop_q && !stop_edge) |=> running) else $error("loop dropped"); // R6
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (rst)
    (stop_edge && !start_edge) |=> !running) else $error("stop ignored"); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_data) |-> dac_valid) else $error("output moved while idle"); // R9
endmodule

// File: rtl/awg_playback.sv
module awg_playback
  import awg_pkg::*;
#(
  parameter int SAMPLE_W   = 12,
  parameter int DEPTH_LOG2 = 10
) (
  input  logic                  bus_clk,
  input  logic                  bus_rst,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [DEPTH_LOG2:0]   bus_addr,
  input  logic [BUS_W-1:0]      bus_wdata,
  output logic [BUS_W-1:0]      bus_rdata,
  input  logic                  cnv_clk,
  input  logic                  cnv_rst,
  output logic [SAMPLE_W-1:0]   dac_data,
  output logic                  dac_valid
);
  logic                  buf_we, start_tog, stop_tog, loop_lvl, ack_tog, running, rd_en;
  logic [SAMPLE_W-1:0]   buf_wdata, buf_q, q_b;
  logic [DEPTH_LOG2-1:0] len_lvl, rd_addr;

  awg_host_regs #(.SW(SAMPLE_W), .AW(DEPTH_LOG2)) regs_i (
    .clk(bus_clk), .rst(bus_rst), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .buf_we(buf_we), .buf_wdata(buf_wdata),
    .buf_q(buf_q), .start_tog(start_tog), .stop_tog(stop_tog), .loop_lvl(loop_lvl),
    .len_lvl(len_lvl), .ack_tog(ack_tog), .run_lvl(running)
  );

  awg_dpram #(.W(SAMPLE_W), .AW(DEPTH_LOG2)) ram_i (
    .clk_a(bus_clk), .we_a(buf_we), .addr_a(bus_addr[DEPTH_LOG2-1:0]),
    .wdata_a(buf_wdata), .q_a(buf_q),
    .clk_b(cnv_clk), .re_b(rd_en), .addr_b(rd_addr), .q_b(q_b)
  );

  awg_sequencer #(.SW(SAMPLE_W), .AW(DEPTH_LOG2)) seq_i (
    .clk(cnv_clk), .rst(cnv_rst), .start_tog(start_tog), .stop_tog(stop_tog),
    .loop_lvl(loop_lvl), .len_lvl(len_lvl), .q_b(q_b), .rd_en(rd_en),
    .rd_addr(rd_addr), .ack_tog(ack_tog), .running(running),
    .dac_data(dac_data), .dac_valid(dac_valid)
  );
endmodule

// File: tb/awg_playback_tb.sv
module awg_playback_tb_top;
  logic        bus_clk = 0, cnv_clk = 0, bus_rst = 1, cnv_rst = 1;
  logic        bus_sel = 0, bus_wr = 0;
  logic [10:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [11:0] dac_data;
  logic        dac_valid;

  int tests = 0, fails = 0, pops = 0, gap_err = 0;
  bit done = 0, gap_watch = 0;
  logic [11:0] exp_q[$];
  logic [11:0] shadow[16];
  string cur_req = "R5";

  always #5  bus_clk = ~bus_clk;
  always #15 cnv_clk = ~cnv_clk;

  awg_playback dut_i (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every strobe
  always @(negedge cnv_clk) begin
    if (!cnv_rst) begin
      if (gap_watch && !dac_valid) gap_err++;
      if (dac_valid) begin
        if (exp_q.size() == 0) check(0, "R4/R7 unexpected sample", dac_data, 0);
        else begin
          logic [11:0] e;
          e = exp_q.pop_front();
          pops++;
          check(dac_data == e, cur_req, dac_data, e);
        end
      end
    end
  end

  task automatic bus_write(input logic [10:0] a, input logic [15:0] d);
    @(negedge bus_clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge bus_clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [10:0] a, output logic [15:0] d);
    @(negedge bus_clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(posedge bus_clk);
    @(negedge bus_clk);
    bus_sel = 0;
    @(posedge bus_clk);
    @(negedge bus_clk);
    d = bus_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [15:0] r;
    int n = 0;
    do begin
      bus_read(11'h400, r);
      n++;
    end while (r[0] && n < 2000);
    check(r[0] == 0, req, r[0], 0);
  endtask

  task automatic cnv_wait(input int n);
    repeat (n) @(negedge cnv_clk);
  endtask

  initial begin
    repeat (150000) @(posedge bus_clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic [11:0] held;
    repeat (6) @(posedge cnv_clk);
    @(negedge bus_clk); bus_rst = 0;
    @(negedge cnv_clk); cnv_rst = 0;
    // R1 reset state
    check(dac_data == 12'h800, "R1 dac_data", dac_data, 12'h800);
    check(dac_valid == 0, "R1 dac_valid", dac_valid, 0);
    bus_read(11'h400, r);
    check(r[0] == 0, "R1 busy", r[0], 0);
    // R2 load buffer, upper nibble set and dropped
    for (int i = 0; i < 16; i++) begin
      shadow[i] = 12'((i * 12'h1d3) ^ 12'h5a7);
      bus_write(11'(i), {4'hC, shadow[i]});
    end
    foreach (shadow[i]) begin
      bus_read(11'(i), r);
      check(r == {4'h0, shadow[i]}, "R2 readback", r, {4'h0, shadow[i]});
    end
    // R3 length register
    bus_write(11'h401, 16'd7);
    bus_read(11'h401, r);
    check(r == 16'd7, "R3 length readback", r, 7);
    // R4 nothing plays without a start
    cnv_wait(60);
    check(pops == 0, "R4 no start no samples", pops, 0);
    // R5 one-shot 0..7, R8 busy
    cur_req = "R5 one-shot order";
    for (int i = 0; i < 8; i++) exp_q.push_back(shadow[i]);
    bus_write(11'h400, 16'h0001);
    bus_read(11'h400, r);
    check(r[0] == 1, "R8 busy after start", r[0], 1);
    wait_idle("R8 busy clears after one-shot");
    cnv_wait(20);
    check(exp_q.size() == 0, "R5 all samples played", exp_q.size(), 0);
    check(dac_valid == 0, "R5 strobe low after run", dac_valid, 0);
    check(dac_data == shadow[7], "R9 hold last sample", dac_data, shadow[7]);
    // R5 single entry run
    bus_write(11'h401, 16'd0);
    exp_q.push_back(shadow[0]);
    bus_write(11'h400, 16'h0001);
    wait_idle("R8 busy clears, length 1");
    cnv_wait(20);
    check(exp_q.size() == 0, "R5 length-1 run", exp_q.size(), 0);
    check(dac_data == shadow[0], "R9 hold after length-1", dac_data, shadow[0]);
    // R6 loop over 0..3, R7 stop, R2 write during play
    cur_req = "R6 loop order";
    bus_write(11'h401, 16'd3);
    for (int k = 0; k < 60; k++)
      for (int i = 0; i < 4; i++) exp_q.push_back(shadow[i]);
    pops = 0;
    bus_write(11'h400, 16'h0005);
    bus_read(11'h400, r);
    check(r[2:0] == 3'b101, "R8 mode and busy readback", r[2:0], 3'b101);
    while (pops < 1) @(negedge cnv_clk);
    @(posedge cnv_clk); gap_watch = 1;
    bus_write(11'd200, 16'h0abc);
    bus_read(11'd200, r);
    check(r == 16'h0abc, "R2 write during playback", r, 16'h0abc);
    while (pops < 30) @(negedge cnv_clk);
    @(posedge cnv_clk); gap_watch = 0;
    check(gap_err == 0, "R6 no gap in loop", gap_err, 0);
    bus_write(11'h400, 16'h0003);
    wait_idle("R7 busy clears after stop");
    cnv_wait(10);
    held = dac_data;
    exp_q.delete();
    cnv_wait(40);
    check(dac_valid == 0, "R7 strobe low after stop", dac_valid, 0);
    check(dac_data == held, "R9 hold after stop", dac_data, held);
    check(pops >= 30, "R6 loop kept running", pops, 30);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule